// File: doc/BRIEF.md
# Successive Approximation Conversion Sequencer

This block runs one binary-search conversion for an analog converter built around an external comparator and a feedback DAC. A high-then-low pulse on `conv_start` starts the search. The block sets the most significant trial bit first. It holds each trial for a fixed number of clocks, so the DAC and the comparator can settle. At the close of each trial it samples the comparator and decides whether the bit stays. The trial register drives the DAC directly. The same register, inverted, is the parallel result.

Each decided bit also leaves at once on a serial line, with its own strobe clock, most significant bit first. A status flag stays high from the accepted start until one clock after the last decision. The parallel word does not change after that until the next accepted start.

The result has no back-pressure path. The parallel word and the serial stream are plain outputs with no valid/ready handshake. The falling `busy` flag marks the parallel word as complete. Each rising `ser_clk` marks one serial bit as valid. A consumer that misses a word loses it.

Top module: `sar_conv_ctrl`

## Requirements
- R1: A synchronous reset, with `rst` high at a clock edge, clears the trial register to 0 and `busy` to 0. `data_n` then reads all ones, and `ser_clk` and `ser_data_n` both read 1.
- R2: When `conv_start` is high at one clock edge and low at the next, and no conversion is running, that second edge starts a conversion. From then on `busy` is 1 and `dac_code` is 0x8000. A rising edge or a steady level on `conv_start` starts nothing.
- R3: Bits are tried one at a time, from bit 15 down to bit 0. Each bit period lasts BIT_CLKS clocks (default 4). When a bit period begins, its bit is set to 1 in `dac_code`.
- R4: At the last clock edge of a bit period, the bit under trial is cleared if `cmp_below` is 1 at that edge (the input is below the DAC). Otherwise the bit stays at 1. `dac_code` does not change at any other edge of the period.
- R5: `busy` falls one clock after the bit 0 decision. `busy` is therefore high for 16*BIT_CLKS+1 clocks. After that, `dac_code` stays fixed until the next accepted start.
- R6: `data_n` is always the bitwise complement of the trial register. After a conversion it equals the complement of the converted value.
- R7: At each decision edge, `ser_clk` goes to 0 and `ser_data_n` takes the complement of the bit just decided. `ser_clk` returns to 1 BIT_CLKS/2 clocks later. Each conversion gives 16 rising edges of `ser_clk`, carrying bit 15 first.
- R8: A falling edge on `conv_start` that arrives while `busy` is 1 is ignored. This includes the final busy clock: the conversion length and the result do not change, and no new conversion follows.
- R9: A value on `cmp_below` at any edge other than the end of a bit period has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_start | input | 1 | Start pulse; its falling edge starts a conversion |
| cmp_below | input | 1 | Comparator result: 1 when the input is below the DAC output |
| dac_code | output | 16 | Trial register, driven to the feedback DAC |
| data_n | output | 16 | Parallel result, complemented |
| busy | output | 1 | High while a conversion is running |
| ser_clk | output | 1 | Serial strobe; data is valid on its rising edge |
| ser_data_n | output | 1 | Serial result bit, complemented |

## Verification
The assertions assume the following about the inputs. `conv_start` holds each level for at least one clock, so that a pulse is seen. `cmp_below` has settled by the last clock of every bit period. BIT_CLKS is even and at least 2, so the serial strobe has a low phase and a high phase.

The stimulus drives every input on the falling clock edge. It holds start pulses for several clocks. It places comparator glitches only on clocks that are not the last clock of a bit period, and it also places extra start pulses inside a running conversion, including its final busy clock.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_FIN  = 2'd2
  } sar_state_e;
endpackage

// File: rtl/sar_start_edge.sv
// Detects a high-to-low change of the start input between two edges.
module sar_start_edge (
  input  logic clk,
  input  logic rst,
  input  logic conv_start,
  output logic start_fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= conv_start;
  end

  assign start_fall = prev_q & ~conv_start;
endmodule

// File: rtl/sar_bit_timer.sv
// Counts the clocks of one bit period and flags its last clock.
module sar_bit_timer #(
  parameter int BIT_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic period_end
);
  localparam int CW = (BIT_CLKS > 1) ? $clog2(BIT_CLKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BIT_CLKS - 1);

  logic [CW-1:0] cnt_q;

  assign period_end = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clear)   cnt_q <= '0;
    else if (period_end) cnt_q <= '0;
    else if (run)        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sar_trial_reg.sv
// Trial register plus a one-hot pointer to the bit under test.
module sar_trial_reg #(
  parameter int RES_BITS = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                decide,
  input  logic                cmp_below,
  output logic [RES_BITS-1:0] code,
  output logic                last_bit,
  output logic                kept_bit
);
  logic [RES_BITS-1:0] code_q;
  logic [RES_BITS-1:0] ptr_q;

  for (genvar i = 0; i < RES_BITS; i++) begin : g_bit
    localparam logic IS_TOP = (i == RES_BITS - 1) ? 1'b1 : 1'b0;
    logic next_trial;
    if (i == RES_BITS - 1) begin : g_top
      assign next_trial = 1'b0;
    end else begin : g_low
      assign next_trial = ptr_q[i+1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        code_q[i] <= 1'b0;
        ptr_q[i]  <= 1'b0;
      end else if (load) begin
        code_q[i] <= IS_TOP;
        ptr_q[i]  <= IS_TOP;
      end else if (decide) begin
        ptr_q[i] <= next_trial;
        if (ptr_q[i])        code_q[i] <= ~cmp_below;
        else if (next_trial) code_q[i] <= 1'b1;
      end
    end
  end

  assign code     = code_q;
  assign last_bit = ptr_q[0];
  assign kept_bit = ~cmp_below;
endmodule

// File: rtl/sar_serial_out.sv
// Presents each decided bit with a strobe that falls on load and rises half a period later.
module sar_serial_out #(
  parameter int BIT_CLKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic bit_in,
  output logic ser_clk,
  output logic ser_data_n
);
  localparam int HALF = (BIT_CLKS / 2 > 0) ? BIT_CLKS / 2 : 1;
  localparam int HW   = $clog2(HALF + 1);

  logic [HW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= '0;
      ser_clk    <= 1'b1;
      ser_data_n <= 1'b1;
    end else if (strobe) begin
      hold_q     <= HW'(HALF);
      ser_clk    <= 1'b0;
      ser_data_n <= ~bit_in;
    end else if (hold_q != '0) begin
      hold_q <= hold_q - 1'b1;
      if (hold_q == HW'(1)) ser_clk <= 1'b1;
    end
  end
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_conv_pkg::*;
#(
  parameter int RES_BITS = 16,
  parameter int BIT_CLKS = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                conv_start,
  input  logic                cmp_below,
  output logic [RES_BITS-1:0] dac_code,
  output logic [RES_BITS-1:0] data_n,
  output logic                busy,
  output logic                ser_clk,
  output logic                ser_data_n
);
  sar_state_e state_q;
  logic       start_fall;
  logic       period_end;
  logic       last_bit;
  logic       kept_bit;
  logic       load;

  assign load = (state_q == ST_IDLE) && start_fall;

  sar_start_edge u_edge (
    .clk        (clk),
    .rst        (rst),
    .conv_start (conv_start),
    .start_fall (start_fall)
  );

  sar_bit_timer #(.BIT_CLKS(BIT_CLKS)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .clear      (load),
    .run        (state_q == ST_CONV),
    .period_end (period_end)
  );

  sar_trial_reg #(.RES_BITS(RES_BITS)) u_trial (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .decide    (period_end),
    .cmp_below (cmp_below),
    .code      (dac_code),
    .last_bit  (last_bit),
    .kept_bit  (kept_bit)
  );

  sar_serial_out #(.BIT_CLKS(BIT_CLKS)) u_ser (
    .clk        (clk),
    .rst        (rst),
    .strobe     (period_end),
    .bit_in     (kept_bit),
    .ser_clk    (ser_clk),
    .ser_data_n (ser_data_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_fall) state_q <= ST_CONV;
        ST_CONV: if (period_end && last_bit) state_q <= ST_FIN;
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state_q != ST_IDLE);
  assign data_n = ~dac_code;
endmodule

// File: rtl/sar_conv_chk.sv
module sar_conv_chk
  import sar_conv_pkg::*;
#(
  parameter int W = 16,
  parameter int P = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] dac_code,
  input logic         busy,
  input logic         ser_clk,
  input logic         ser_data_n,
  input sar_state_e   state_q,
  input logic         start_fall,
  input logic         period_end
);
  localparam int HALF = (P / 2 > 0) ? P / 2 : 1;
  localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

  logic [7:0] low_run_q;
  always_ff @(posedge clk) begin
    if (rst || ser_clk)       low_run_q <= '0;
    else if (low_run_q != '1) low_run_q <= low_run_q + 1'b1;
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && start_fall) |=> (busy && dac_code == MSB_ONLY));

  // R4
  hold_in_period_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CONV && !period_end) |=> $stable(dac_code));

  // R5
  fin_release_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FIN) |=> (!busy && $stable(dac_code)));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start_fall) |=> $stable(dac_code));

  // R8
  late_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FIN && start_fall) |=> !busy);

  // R7
  sclk_low_width_chk: assert property (@(posedge clk) disable iff (rst)
    !ser_clk |-> (low_run_q < 8'(HALF)));

  // R7
  sdata_stable_chk: assert property (@(posedge clk) disable iff (rst)
    ser_clk |-> $stable(ser_data_n));
endmodule

bind sar_conv_ctrl sar_conv_chk #(.W(RES_BITS), .P(BIT_CLKS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dac_code   (dac_code),
  .busy       (busy),
  .ser_clk    (ser_clk),
  .ser_data_n (ser_data_n),
  .state_q    (state_q),
  .start_fall (start_fall),
  .period_end (period_end)
);

// File: tb/sar_conv_ctrl_bench.sv
module sar_conv_ctrl_bench;
  localparam int W = 16;
  localparam int P = 4;
  localparam int BUSY_LEN = 16 * P + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic conv_start = 1'b0;
  logic cmp_r = 1'b0;
  logic [W-1:0] dac_code, data_n;
  logic busy, ser_clk, ser_data_n;

  int vin = 0;
  bit noise_en = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int total = 0;
  int bad = 0;
  int cyc = 0;

  // behavioural reference state
  int m_busy = 0, m_fin = 0, m_code = 0, m_bit = 15, m_cnt = 0;
  int m_prev = 0, m_sclk = 1, m_sdat = 1, m_sh = 0;

  // serial capture
  logic [W-1:0] ser_word = '0;
  logic last_sclk = 1'b1;

  sar_conv_ctrl #(.RES_BITS(W), .BIT_CLKS(P)) u_sar_conv_ctrl (
    .clk(clk), .rst(rst), .conv_start(conv_start), .cmp_below(cmp_r),
    .dac_code(dac_code), .data_n(data_n), .busy(busy),
    .ser_clk(ser_clk), .ser_data_n(ser_data_n)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // reference model, one step per rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_fin = 0; m_code = 0; m_bit = 15; m_cnt = 0;
      m_prev = 0; m_sclk = 1; m_sdat = 1; m_sh = 0;
    end else begin
      int fall;
      fall = (m_prev == 1 && conv_start == 1'b0) ? 1 : 0;
      m_prev = conv_start ? 1 : 0;
      if (m_sh > 0) begin
        m_sh--;
        if (m_sh == 0) m_sclk = 1;
      end
      if (m_fin == 1) begin
        m_fin = 0; m_busy = 0;
      end else if (m_busy == 1) begin
        if (m_cnt == P - 1) begin
          m_cnt = 0;
          if (cmp_r) m_code = m_code & ~(1 << m_bit);
          m_sdat = cmp_r ? 1 : 0;
          m_sclk = 0;
          m_sh = P / 2;
          if (m_bit == 0) m_fin = 1;
          else begin
            m_bit--;
            m_code = m_code | (1 << m_bit);
          end
        end else begin
          m_cnt++;
        end
      end else if (fall == 1) begin
        m_busy = 1; m_code = 1 << 15; m_bit = 15; m_cnt = 0;
      end
    end
  end

  // per-clock comparison and comparator drive
  always @(negedge clk) begin
    bit noise;
    cyc++;
    chk(busy == m_busy[0], "R5 busy", busy, m_busy);
    chk(dac_code == m_code[W-1:0], "R3 dac_code", dac_code, m_code);
    chk(data_n == ~m_code[W-1:0], "R6 data_n", data_n, (~m_code) & 16'hFFFF);
    chk(ser_clk == m_sclk[0], "R7 ser_clk", ser_clk, m_sclk);
    chk(ser_data_n == m_sdat[0], "R7 ser_data_n", ser_data_n, m_sdat);
    if (!last_sclk && ser_clk) ser_word = {ser_word[W-2:0], ~ser_data_n};
    last_sclk = ser_clk;
    // R9: glitches only away from the deciding edge
    noise = noise_en && (m_busy == 1) && (m_fin == 0) && (m_cnt != P - 1) && lfsr[0];
    cmp_r = ((vin < m_code) ? 1'b1 : 1'b0) ^ noise;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic convert(input int v, input int hold, input int inj_hi, input int inj_lo);
    int n;
    vin = v;
    ser_word = '0;
    @(negedge clk);
    conv_start = 1'b1;
    repeat (hold) @(negedge clk);
    chk(busy == 1'b0, "R2 no start on rise", busy, 0);
    conv_start = 1'b0;
    @(negedge clk);
    chk(busy == 1'b1 && dac_code == 16'h8000, "R2 start", dac_code, 16'h8000);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      if (n == inj_hi) conv_start = 1'b1;
      if (n == inj_lo) conv_start = 1'b0;
      @(negedge clk);
    end
    chk(n == BUSY_LEN, "R5 busy length", n, BUSY_LEN);
    chk(dac_code == v[W-1:0], "R4 result", dac_code, v);
    chk(data_n == ~v[W-1:0], "R6 result", data_n, (~v) & 16'hFFFF);
    repeat (P) @(negedge clk);
    chk(ser_word == v[W-1:0], "R7 serial word", ser_word, v);
    chk(busy == 1'b0, "R8 stays idle", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && data_n == 16'hFFFF && ser_clk && ser_data_n, "R1 reset", data_n, 16'hFFFF);
    rst = 1'b0;
    @(negedge clk);
    convert(16'h0000, 2, 0, 0);
    convert(16'hFFFF, 2, 0, 0);
    convert(16'h8000, 1, 0, 0);
    convert(16'h7FFF, 3, 0, 0);
    convert(16'h1234, 12, 0, 0);                  // R2 long high level
    convert(16'hA5A5, 2, 10, 14);                 // R8 start mid-conversion
    convert(16'h5A5A, 2, BUSY_LEN - 3, BUSY_LEN); // R8 start in last busy clock
    noise_en = 1'b1;
    convert(16'hC3E1, 2, 0, 0);                   // R9 comparator glitches
    convert(16'h0001, 2, 0, 0);
    noise_en = 1'b0;
    // R1 reset in mid-conversion
    vin = 16'h4321;
    conv_start = 1'b1;
    @(negedge clk);
    conv_start = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 1'b0 && data_n == 16'hFFFF && ser_clk && ser_data_n, "R1 mid reset", data_n, 16'hFFFF);
    rst = 1'b0;
    convert(16'h4321, 2, 0, 0);
    finish_run();
  end
endmodule